// File: doc/BRIEF.md
# Configurable Pixel Component Extractor

This block sits between a framebuffer fetch path and a display output. Each beat it takes one raw pixel word and produces a registered 8-bit red, green and blue triple. Software sets the number of bytes per pixel and, for each colour, where the component starts in the pixel word, how many bits it has, and an 8-bit fallback value. With these settings one datapath can serve 8-bit, 16-bit, 24-bit and 32-bit pixel layouts.

Short components are widened to 8 bits by repeating their bit pattern from the top down. Long components are cut to their upper 8 bits. The fallback value replaces the extracted component in three cases: the component length is zero, the pixel lies outside the visible area, or the fetch path reports an underrun. A bright fallback on one colour therefore marks underruns on screen.

Top module: `pix_field_extract`

## Requirements
- R1: Bits [4:3] of `fmt_cfg` hold the byte count minus one (0 means 1 byte, 3 means 4 bytes). Bytes of `pix_data` at or above that count read as zero before extraction.
- R2: In each colour select word, bits [4:0] give the lowest bit index of the component and bits [11:8] give its length, from 0 to 15. Positions above bit 31 read as zero.
- R3: A component of length 8 to 15 outputs its most significant 8 bits.
- R4: A component of length 1 to 7 is placed at the top of the 8-bit output, and its bit pattern repeats downward to fill the remaining low bits.
- R5: A colour whose length field is zero outputs bits [23:16] of its select word.
- R6: When `pix_visible` is low, all three colours output their own bits [23:16] values.
- R7: When `pix_underrun` is high, all three colours output their own bits [23:16] values.
- R8: The outputs change one clock after a beat with `pix_valid` high, and `rgb_valid` equals `pix_valid` from the previous clock.
- R9: While `pix_valid` is low, the colour outputs keep their last values.
- R10: After reset, all colour outputs and `rgb_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_cfg | input | 32 | Pixel size word; bits [4:3] hold bytes per pixel minus one |
| sel_r | input | 32 | Red select word: lowest bit, length, fallback |
| sel_g | input | 32 | Green select word |
| sel_b | input | 32 | Blue select word |
| pix_data | input | 32 | Raw pixel word |
| pix_valid | input | 1 | Pixel word is present this beat |
| pix_visible | input | 1 | Pixel lies inside the visible area |
| pix_underrun | input | 1 | Fetch path has run dry this beat |
| rgb_r | output | 8 | Red output |
| rgb_g | output | 8 | Green output |
| rgb_b | output | 8 | Blue output |
| rgb_valid | output | 1 | Output triple is valid |

## Verification
The hardest cases to reach are extraction windows that cross the byte-count cutoff or run past bit 31. In those cases, masked or missing bits must read as zero while the other bits in the same field stay live. The stimulus places fields whose upper parts lie in dropped bytes, or beyond the top of the word, and fills those positions with ones so that any leak shows in the output. Odd lengths are handled the same way. Lengths 3, 5, 6, 12 and 15 are driven with asymmetric bit patterns, so that a wrong repeat phase or a wrong truncation point gives a value different from the expected one.

// File: rtl/pix_field_extract.sv
module pix_field_extract #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      fmt_cfg,
  input  logic [31:0]      sel_r,
  input  logic [31:0]      sel_g,
  input  logic [31:0]      sel_b,
  input  logic [31:0]      pix_data,
  input  logic             pix_valid,
  input  logic             pix_visible,
  input  logic             pix_underrun,
  output logic [OUT_W-1:0] rgb_r,
  output logic [OUT_W-1:0] rgb_g,
  output logic [OUT_W-1:0] rgb_b,
  output logic             rgb_valid
);
  localparam int NCH = 3;
  localparam int FW  = 15;

  function automatic logic [OUT_W-1:0] justify(input logic [FW-1:0] f, input logic [3:0] n);
    logic [OUT_W-1:0] o;
    logic [3:0] idx;
    logic [FW-1:0] sh;
    o = '0;
    if (n >= 4'(OUT_W)) begin
      sh = f >> (n - 4'(OUT_W));
      o = sh[OUT_W-1:0];
    end else if (n != 4'd0) begin
      idx = n - 4'd1;
      for (int i = OUT_W-1; i >= 0; i--) begin
        o[i] = f[idx];
        idx = (idx == 4'd0) ? n - 4'd1 : idx - 4'd1;
      end
    end
    return o;
  endfunction

  logic [1:0]  bpp_code;
  logic [31:0] masked;
  logic        use_dflt_all;
  logic [31:0] sel [NCH];
  logic [OUT_W-1:0] nxt [NCH];
  logic [OUT_W-1:0] q   [NCH];

  assign bpp_code     = fmt_cfg[4:3];
  assign use_dflt_all = !pix_visible || pix_underrun;
  assign sel[0] = sel_r;
  assign sel[1] = sel_g;
  assign sel[2] = sel_b;

  for (genvar b = 0; b < 4; b++) begin : g_byte
    assign masked[8*b +: 8] = (b <= int'(bpp_code)) ? pix_data[8*b +: 8] : 8'h00;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [46:0]   wide;
    logic [15:0]   lmask;
    logic [FW-1:0] field;
    logic [3:0]    len;
    assign len   = sel[c][11:8];
    assign wide  = {15'd0, masked} >> sel[c][4:0];
    assign lmask = (16'd1 << len) - 16'd1;
    assign field = wide[FW-1:0] & lmask[FW-1:0];
    assign nxt[c] = (use_dflt_all || len == 4'd0) ? sel[c][23:16] : justify(field, len);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[c] <= '0;
      else if (pix_valid) q[c] <= nxt[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb_valid <= 1'b0;
    else        rgb_valid <= pix_valid;
  end

  assign rgb_r = q[0];
  assign rgb_g = q[1];
  assign rgb_b = q[2];

  a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> rgb_valid);
  a_r8_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !rgb_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> ($stable(rgb_r) && $stable(rgb_g) && $stable(rgb_b)));
  a_r6_blank_dflt: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_visible) |=> (rgb_r == $past(sel_r[23:16])));
  a_r7_underrun_dflt: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_underrun) |=> (rgb_g == $past(sel_g[23:16])));
  a_r5_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && sel_b[11:8] == 4'd0) |=> (rgb_b == $past(sel_b[23:16])));
endmodule

// File: tb/sim_pix_field_extract.sv
module sim_pix_field_extract;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] fmt_cfg = '0, sel_r = '0, sel_g = '0, sel_b = '0, pix_data = '0;
  logic pix_valid = 1'b0, pix_visible = 1'b1, pix_underrun = 1'b0;
  logic [7:0] rgb_r, rgb_g, rgb_b;
  logic rgb_valid;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pix_field_extract u0 (.*);

  localparam int NV = 10;
  // {fmt, sel_r, sel_g, sel_b, pix, visible, underrun, expected rgb}
  localparam logic [185:0] VEC [NV] = '{
    {32'h18, 32'h00000810, 32'h00000808, 32'h00000800, 32'h00123456, 1'b1, 1'b0, 24'h123456},
    {32'h08, 32'h0000050B, 32'h00000605, 32'h00000500, 32'hFFFFF800, 1'b1, 1'b0, 24'hFF0000},
    {32'h08, 32'h0000050B, 32'h00000605, 32'h00000500, 32'h00008435, 1'b1, 1'b0, 24'h8486AD},
    {32'h00, 32'h00000305, 32'h00000302, 32'h00000200, 32'hABCDEFE6, 1'b1, 1'b0, 24'hFF24AA},
    {32'h18, 32'h005A0000, 32'h00000808, 32'h00C30000, 32'h00123456, 1'b1, 1'b0, 24'h5A34C3},
    {32'h18, 32'h00110810, 32'h00220808, 32'h00330800, 32'h00123456, 1'b0, 1'b0, 24'h112233},
    {32'h18, 32'h00110810, 32'h00220808, 32'h00330800, 32'h00123456, 1'b1, 1'b1, 24'h112233},
    {32'h18, 32'h00000C00, 32'h00000C14, 32'h00000F04, 32'hABCDE123, 1'b1, 1'b0, 24'h12ABBC},
    {32'h10, 32'h00000818, 32'h00000810, 32'h00000800, 32'hFF804020, 1'b1, 1'b0, 24'h008020},
    {32'h18, 32'h0000081C, 32'h00000000, 32'h00000000, 32'hA0000000, 1'b1, 1'b0, 24'h0A0000}
  };
  localparam string TAG [NV] = '{"R2", "R1", "R4", "R4", "R5", "R6", "R7", "R3", "R1", "R2"};

  task automatic check(input string tag, input logic [24:0] act, input logic [24:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [185:0] v, input logic vld);
    @(negedge clk);
    fmt_cfg = v[185:154]; sel_r = v[153:122]; sel_g = v[121:90]; sel_b = v[89:58];
    pix_data = v[57:26]; pix_visible = v[25]; pix_underrun = v[24]; pix_valid = vld;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", {rgb_valid, rgb_r, rgb_g, rgb_b}, 25'h0);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i], 1'b1);
      check(TAG[i], {rgb_valid, rgb_r, rgb_g, rgb_b}, {1'b1, VEC[i][23:0]});
    end
    // R9: invalid beat with a different word must not disturb the outputs
    apply(VEC[0], 1'b0);
    check("R9", {rgb_valid, rgb_r, rgb_g, rgb_b}, {1'b0, 24'h0A0000});
    // R8: output arrives exactly one clock after the valid beat
    @(negedge clk);
    fmt_cfg = 32'h18; sel_r = 32'h00000810; sel_g = 32'h00000808; sel_b = 32'h00000800;
    pix_data = 32'h00C0FFEE; pix_visible = 1'b1; pix_underrun = 1'b0; pix_valid = 1'b1;
    #1;
    check("R8", {rgb_valid, rgb_r, rgb_g, rgb_b}, {1'b0, 24'h0A0000});
    @(posedge clk); #1;
    check("R8", {rgb_valid, rgb_r, rgb_g, rgb_b}, {1'b1, 24'hC0FFEE});
    @(negedge clk) pix_valid = 1'b0;
    @(posedge clk); #1;
    check("R8", {24'h0, rgb_valid}, 25'h0);
    // R10: reset mid-run clears everything
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R10", {rgb_valid, rgb_r, rgb_g, rgb_b}, 25'h0);
    @(negedge clk) rst_n = 1'b1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule